// File: doc/BRIEF.md
# Switchable-Depth UART Receive Buffer

This block holds characters that a serial deserializer has assembled until software reads them. It runs in one of two modes, chosen by a FIFO-enable input. With the input high it is a circular queue of `DEPTH` entries (16 by default). With the input low it shrinks to a single holding register. Each entry carries an 8-bit character and four flag bits: framing error, parity error, line break and overrun. Any change of the enable input discards everything stored.

A push port takes characters from the deserializer, with a ready signal that shows whether there is room. A read strobe pops the entry at the head of the buffer and returns it in the same cycle. The same read also copies the entry's four flag bits into a receive-status register, which a separate clear strobe empties. The block drives empty and full flags and a receive-interrupt request based on fill level. Masking that request is left to the surrounding logic.

The mode is kept by a two-state machine. In `MODE_HOLD` the depth is one. In `MODE_QUEUE` the depth is `DEPTH`. The transition ENABLE (hold to queue) is taken when the enable input is seen high in `MODE_HOLD`. The transition DISABLE (queue to hold) is taken when it is seen low in `MODE_QUEUE`. Both transitions flush the buffer in the cycle they are taken.

Top module: `rx_hold_fifo`

## Requirements
- R1: After reset the buffer is empty and the mode is `MODE_HOLD`. The outputs are `rx_empty`=1, `rx_full`=0, `rx_irq`=0, `stat_q`=0, `ovr_o`=0 and `push_ready`=1.
- R2: In `MODE_QUEUE` the buffer accepts up to `DEPTH` pushes and returns them in push order. `rx_full` rises on the push that makes the count equal `DEPTH`, and `push_ready` is low while full.
- R3: In `MODE_HOLD` a single push makes `rx_full`=1 and `push_ready`=0.
- R4: A push stores at (head + count) mod depth, and a pop moves the head forward mod depth. Order is kept when the pointers wrap past the last slot.
- R5: While `rd_en` is high, `rd_word` shows the entry at the head. A read with a nonzero count removes that entry, and `rx_empty` rises when the count reaches zero. A read of an empty buffer leaves it empty and does not move the head.
- R6: When `fifo_en` differs from the current mode, the buffer is flushed at the next edge (`rx_empty`=1, `rx_full`=0, contents dropped). A push offered in that cycle is refused: `push_ready`=0 and no overrun is flagged.
- R7: `rx_irq` is set when a push brings the count to `TRIG` (default 1). It is cleared when a read leaves the count at `TRIG`-1.
- R8: Each read loads `stat_q` with entry bits [11:8] (bit 8 framing, bit 9 parity, bit 10 break, bit 11 overrun). A `stat_clr` pulse without a read clears `stat_q` to 0.
- R9: A push with `push_brk`=1 stores the word 0x400: break bit 10 set, data zero, other flags clear.
- R10: A push offered while full is dropped. `ovr_o` pulses for one cycle after the edge, and bit 11 is set in the newest stored entry.
- R11: A push and a read in the same cycle on a non-empty, non-full buffer leave the count unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | High selects queue mode, low selects single holding register |
| push_valid | input | 1 | Deserializer offers a character |
| push_ready | output | 1 | Room for a push in this cycle |
| push_char | input | 8 | Received character |
| push_frm_err | input | 1 | Framing error for this character |
| push_par_err | input | 1 | Parity error for this character |
| push_brk | input | 1 | Line break received; stores 0x400 |
| rd_en | input | 1 | Data-register read strobe (pop) |
| rd_word | output | 12 | Entry at the head: flags [11:8], character [7:0] |
| stat_clr | input | 1 | Write strobe that clears the status register |
| stat_q | output | 4 | Receive-status register (flag bits of the last read entry) |
| rx_empty | output | 1 | Buffer empty |
| rx_full | output | 1 | Count equals effective depth |
| rx_irq | output | 1 | Receive-interrupt request |
| ovr_o | output | 1 | One-cycle pulse after a push was dropped while full |

## Verification
The bench pushes into the single holding register and then offers a second push, which separates the depth-one mode from the queue and shows the overrun mark landing on the stored entry. In queue mode it fills the buffer completely, drains part of it and refills it so the pointers wrap. This shows whether slot addressing uses head plus count modulo the depth, and a break entry sits among the refills to check its fixed encoding. It also reads an empty buffer, pushes and reads in the same cycle, and changes the enable while a push is offered. These patterns show whether the head moves when it must not, whether the count stays put on a combined push and pop, and whether the flush wins over an incoming character.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int CHAR_W  = 8;
    localparam int WORD_W  = 12;
    localparam int FRM_BIT = 8;
    localparam int PAR_BIT = 9;
    localparam int BRK_BIT = 10;
    localparam int OVR_BIT = 11;

    typedef enum logic {
        MODE_HOLD  = 1'b0,
        MODE_QUEUE = 1'b1
    } rxq_mode_e;
endpackage

// File: rtl/rxq_mode_fsm.sv
module rxq_mode_fsm
    import rxq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fifo_en,
    output rxq_mode_e mode,
    output logic      flush
);
    rxq_mode_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MODE_HOLD;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            MODE_HOLD:  if (fifo_en)  nxt = MODE_QUEUE;
            MODE_QUEUE: if (!fifo_en) nxt = MODE_HOLD;
            default:    nxt = MODE_HOLD;
        endcase
    end

    always_comb begin
        mode  = state;
        flush = (nxt != state);
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 12,
    parameter int MARK  = 11,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [W-1:0]  wr_word,
    input  logic          mark_en,
    input  logic [PW-1:0] mark_idx,
    input  logic [PW-1:0] rd_idx,
    output logic [W-1:0]  rd_word
);
    logic [W-1:0] slots [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_en && wr_idx == PW'(i))
                    slots[i] <= wr_word;
                else if (mark_en && mark_idx == PW'(i))
                    slots[i][MARK] <= 1'b1;
            end
        end
    end

    assign rd_word = slots[rd_idx];
endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fifo_en,
    input  logic                push_valid,
    output logic                push_ready,
    input  logic [CHAR_W-1:0]   push_char,
    input  logic                push_frm_err,
    input  logic                push_par_err,
    input  logic                push_brk,
    input  logic                rd_en,
    output logic [WORD_W-1:0]   rd_word,
    input  logic                stat_clr,
    output logic [3:0]          stat_q,
    output logic                rx_empty,
    output logic                rx_full,
    output logic                rx_irq,
    output logic                ovr_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    rxq_mode_e       mode;
    logic            flush;
    logic [CW-1:0]   cnt, cnt_nxt, eff_depth;
    logic [PW-1:0]   rp, ptr_mask, wr_idx, last_idx, cnt_lo;
    logic            push_acc, push_drop, pop;
    logic [WORD_W-1:0] in_word;

    rxq_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .mode    (mode),
        .flush   (flush)
    );

    always_comb begin
        eff_depth = (mode == MODE_QUEUE) ? CW'(DEPTH) : CW'(1);
        ptr_mask  = (mode == MODE_QUEUE) ? PW'(DEPTH - 1) : '0;
        cnt_lo    = cnt[PW-1:0];
        wr_idx    = (rp + cnt_lo) & ptr_mask;
        last_idx  = (rp + cnt_lo - PW'(1)) & ptr_mask;
        push_ready = !flush && (cnt < eff_depth);
        push_acc   = push_valid && push_ready;
        push_drop  = push_valid && !flush && (cnt == eff_depth);
        pop        = rd_en && !flush && (cnt != '0);
        if (push_brk) in_word = WORD_W'(1) << BRK_BIT;
        else          in_word = {2'b00, push_par_err, push_frm_err, push_char};
        cnt_nxt = cnt;
        if (flush)                 cnt_nxt = '0;
        else if (push_acc && !pop) cnt_nxt = cnt + CW'(1);
        else if (pop && !push_acc) cnt_nxt = cnt - CW'(1);
    end

    rxq_store #(.DEPTH(DEPTH), .W(WORD_W), .MARK(OVR_BIT)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (push_acc),
        .wr_idx   (wr_idx),
        .wr_word  (in_word),
        .mark_en  (push_drop),
        .mark_idx (last_idx),
        .rd_idx   (rp),
        .rd_word  (rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp     <= '0;
            cnt    <= '0;
            rx_irq <= 1'b0;
            stat_q <= '0;
            ovr_o  <= 1'b0;
        end else begin
            cnt   <= cnt_nxt;
            ovr_o <= push_drop;
            if (flush)    rp <= '0;
            else if (pop) rp <= (rp + PW'(1)) & ptr_mask;
            if (push_acc && cnt_nxt == CW'(TRIG))
                rx_irq <= 1'b1;
            else if (rd_en && !flush && cnt_nxt == CW'(TRIG - 1))
                rx_irq <= 1'b0;
            if (rd_en)         stat_q <= rd_word[OVR_BIT:FRM_BIT];
            else if (stat_clr) stat_q <= '0;
        end
    end

    assign rx_empty = (cnt == '0);
    assign rx_full  = (cnt == eff_depth);

    // R2
    full_blocks_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !push_ready);
    // R6
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rx_empty && !rx_full));
    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> !rx_empty);
    // R10
    ovr_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> $past(rx_full));
    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !rd_en) |=> (stat_q == 4'h0));
    // R5
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rx_empty && !push_valid && !flush) |=> rx_empty);
endmodule

// File: tb/tb_rx_hold_fifo.sv
`timescale 1ns/1ps
module tb_rx_hold_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic        push_valid = 1'b0;
    logic        push_ready;
    logic [7:0]  push_char = 8'h00;
    logic        push_frm_err = 1'b0;
    logic        push_par_err = 1'b0;
    logic        push_brk = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_word;
    logic        stat_clr = 1'b0;
    logic [3:0]  stat_q;
    logic        rx_empty, rx_full, rx_irq, ovr_o;

    int checks = 0;
    int fails  = 0;
    int m_cnt  = 0;
    int m_depth = 1;
    logic [11:0] sb [$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_hold_fifo dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .push_valid(push_valid), .push_ready(push_ready), .push_char(push_char),
        .push_frm_err(push_frm_err), .push_par_err(push_par_err), .push_brk(push_brk),
        .rd_en(rd_en), .rd_word(rd_word), .stat_clr(stat_clr), .stat_q(stat_q),
        .rx_empty(rx_empty), .rx_full(rx_full), .rx_irq(rx_irq), .ovr_o(ovr_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // driver: offers one push, records expected entry in the scoreboard
    task automatic drv_push(input logic [7:0] c, input logic fe, input logic pe, input logic bk);
        push_valid = 1'b1; push_char = c; push_frm_err = fe;
        push_par_err = pe; push_brk = bk;
        if (m_cnt < m_depth) begin
            sb.push_back(bk ? 12'h400 : {2'b00, pe, fe, c});
            m_cnt++;
        end else if (sb.size() != 0) begin
            sb[sb.size()-1][11] = 1'b1;
        end
        tick();
        push_valid = 1'b0; push_brk = 1'b0; push_frm_err = 1'b0; push_par_err = 1'b0;
    endtask

    // monitor: pops one read and compares with the scoreboard head
    task automatic mon_pop(input string req);
        logic [11:0] e;
        rd_en = 1'b1;
        #1;
        e = sb.pop_front();
        m_cnt--;
        chk(req, int'(rd_word), int'(e));
        tick();
        rd_en = 1'b0;
        chk("R8 status load", int'(stat_q), int'(e[11:8]));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 empty", int'(rx_empty), 1);
        chk("R1 full", int'(rx_full), 0);
        chk("R1 irq", int'(rx_irq), 0);
        chk("R1 stat", int'(stat_q), 0);
        chk("R1 ready", int'(push_ready), 1);
        chk("R1 ovr", int'(ovr_o), 0);

        // R3 hold mode, R7 irq set
        drv_push(8'h41, 1'b1, 1'b0, 1'b0);
        chk("R3 full", int'(rx_full), 1);
        chk("R3 ready", int'(push_ready), 0);
        chk("R7 irq set", int'(rx_irq), 1);
        // R10 overrun in hold mode
        drv_push(8'h42, 1'b0, 1'b0, 1'b0);
        chk("R10 ovr pulse", int'(ovr_o), 1);
        tick();
        chk("R10 ovr single", int'(ovr_o), 0);
        mon_pop("R10 overrun mark");
        chk("R5 empty after read", int'(rx_empty), 1);
        chk("R7 irq clear", int'(rx_irq), 0);
        // R8 clear
        stat_clr = 1'b1; tick(); stat_clr = 1'b0;
        chk("R8 clear", int'(stat_q), 0);

        // R6 enable change with push offered
        drv_push(8'h43, 1'b0, 1'b0, 1'b0);
        fifo_en = 1'b1; push_valid = 1'b1; push_char = 8'h44;
        #1;
        chk("R6 ready low on change", int'(push_ready), 0);
        tick();
        push_valid = 1'b0;
        sb.delete(); m_cnt = 0; m_depth = 16;
        chk("R6 empty", int'(rx_empty), 1);
        chk("R6 full", int'(rx_full), 0);
        chk("R6 no ovr", int'(ovr_o), 0);

        // R2 fill queue
        for (int i = 0; i < 16; i++) begin
            drv_push(8'h10 + 8'(i), 1'b0, 1'(i % 2), 1'b0);
            if (i == 14) chk("R2 not full at 15", int'(rx_full), 0);
        end
        chk("R2 full at 16", int'(rx_full), 1);
        chk("R2 ready low", int'(push_ready), 0);
        for (int i = 0; i < 5; i++) mon_pop("R2 order");
        // R4 wrap, R9 break
        drv_push(8'h20, 1'b0, 1'b0, 1'b0);
        drv_push(8'h21, 1'b1, 1'b1, 1'b0);
        drv_push(8'h99, 1'b0, 1'b0, 1'b1);
        drv_push(8'h23, 1'b0, 1'b0, 1'b0);
        drv_push(8'h24, 1'b0, 1'b0, 1'b0);
        chk("R4 full after wrap", int'(rx_full), 1);
        for (int i = 0; i < 16; i++) mon_pop((i == 13) ? "R9 break word" : "R4 wrap order");
        chk("R5 empty", int'(rx_empty), 1);
        chk("R7 irq low", int'(rx_irq), 0);

        // R5 read while empty
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        chk("R5 still empty", int'(rx_empty), 1);
        drv_push(8'h55, 1'b0, 1'b0, 1'b0);
        mon_pop("R5 head unmoved");

        // R11 simultaneous push and read
        drv_push(8'h61, 1'b0, 1'b0, 1'b0);
        drv_push(8'h62, 1'b0, 1'b0, 1'b0);
        sb.push_back({4'h0, 8'h63});
        m_cnt++;
        push_valid = 1'b1; push_char = 8'h63;
        mon_pop("R11 head during push");
        push_valid = 1'b0;
        chk("R11 not empty", int'(rx_empty), 0);
        mon_pop("R11 order");
        mon_pop("R11 order");
        chk("R11 drained", int'(rx_empty), 1);

        // R6 disable with content
        drv_push(8'h70, 1'b0, 1'b0, 1'b0);
        drv_push(8'h71, 1'b0, 1'b0, 1'b0);
        fifo_en = 1'b0; tick();
        sb.delete(); m_cnt = 0; m_depth = 1;
        chk("R6 flushed on disable", int'(rx_empty), 1);
        drv_push(8'h72, 1'b0, 1'b0, 1'b0);
        chk("R3 full again", int'(rx_full), 1);
        mon_pop("R3 single entry");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule